// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Datapath

This block is the datapath half of a small 32-bit load/store processor that spreads each instruction over several clock cycles. Three resources are shared across those cycles: one ALU, one memory array that holds both program and data, and one register file with 32 entries. Holding registers keep every intermediate value from one cycle to the next. These are the program counter, the fetched instruction, the loaded data word, the two operands read from the register file, and the ALU result. Source multiplexers choose what feeds the memory address, each ALU operand, the program counter and the register-file write port. The next-instruction address, the branch target and the load/store address are all computed by the single ALU. There is no separate adder for any of them.

An external sequencer drives the block one cycle at a time. It sets a load enable for each holding register, the select of every multiplexer, a memory write strobe, a register-file write strobe and a 3-bit ALU operation. It receives back the opcode and function fields of the held instruction and a flag that reports whether the two held operands are equal. All control and status pins are plain per-cycle levels with no handshake. Any value the sequencer samples is valid for the whole cycle after the edge that loaded it.

The memory is word-addressed inside the block. On reset it is reloaded from a boot image parameter, which is the only way a program and its data enter it. R-type arithmetic, loads, stores, equality branches and absolute jumps can all be sequenced through it.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first enabled load, every holding register and every register-file entry is zero. The memory holds the boot image in words 0 to IMG_WORDS-1 and zero above that. The outputs therefore read `opcode`=0, `funct`=0, `zero`=1.
- R2: The memory address is the program counter when `addr_sel`=0 and the held ALU result when `addr_sel`=1. The word index is taken from byte-address bits [log2(MEM_WORDS)+1:2].
- R3: `ir_we` loads the addressed memory word into the instruction register, and `dr_we` loads it into the data register. `opcode` is instruction bits [31:26] and `funct` is bits [5:0].
- R4: `a_we` and `b_we` load the register-file entries named by instruction bits [25:21] and [20:16]. When a register-file write happens on the same edge, the operands take the value held before that write.
- R5: ALU operand A is the program counter when `a_sel`=0 and operand register A when `a_sel`=1. Operand B is selected by `b_sel`: 0 gives operand register B, 1 gives the constant 4, 2 gives the sign-extended bits [15:0], and 3 gives that sign-extended value shifted left by 2.
- R6: `alu_op` codes: 0 is AND, 1 is OR, 2 is ADD, 6 is SUB, 7 is signed set-less-than giving 1 or 0. Any other code gives zero.
- R7: With `pc_we`, the program counter loads from a source chosen by `pc_sel`. 0 selects the ALU output of the same cycle and 1 selects the held ALU result. 2 or 3 selects the jump address: PC bits [31:28], then instruction bits [25:0], then two zero bits.
- R8: `rf_we` writes the entry named by instruction bits [15:11] when `dst_sel`=1, or by bits [20:16] when `dst_sel`=0. The data is the held ALU result when `wb_sel`=0 and the data register when `wb_sel`=1. Entry 0 always reads as zero.
- R9: A holding register whose load enable is low keeps its value.
- R10: `zero` is 1 exactly when operand register A minus operand register B is zero.
- R11: `mem_we` writes operand register B into the addressed memory word on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_we | input | 1 | Program counter load enable |
| ir_we | input | 1 | Instruction register load enable |
| dr_we | input | 1 | Data register load enable |
| a_we | input | 1 | Operand register A load enable |
| b_we | input | 1 | Operand register B load enable |
| res_we | input | 1 | ALU result register load enable |
| addr_sel | input | 1 | Memory address: 0 program counter, 1 held result |
| mem_we | input | 1 | Memory write strobe |
| a_sel | input | 1 | ALU operand A: 0 program counter, 1 register A |
| b_sel | input | 2 | ALU operand B: register B, 4, immediate, immediate<<2 |
| pc_sel | input | 2 | Program counter source: ALU, held result, jump |
| wb_sel | input | 1 | Register write data: 0 held result, 1 data register |
| dst_sel | input | 1 | Register write index: 0 bits [20:16], 1 bits [15:11] |
| rf_we | input | 1 | Register-file write strobe |
| alu_op | input | 3 | ALU operation code |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | Operand A equals operand B |

## Verification
Two functions can fall in one cycle: a register-file write and the capture of the operand registers. The bench provokes this with a cycle that asserts `rf_we` together with `a_we` and `b_we` on the same target entry. It expects `zero` to show the old contents first and the new contents only after a second capture. The fetch edge is a second case, because it loads the instruction register from memory while the program counter takes PC+4 from the shared ALU. It is judged by fetching consecutive words and by a branch that must skip exactly one word. Stores are judged by jumping to the stored word and fetching it as an instruction.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned FUNCT_W   = 6;
  localparam int unsigned REGIDX_W  = 5;
  localparam int unsigned IMM_W     = 16;
  localparam int unsigned TARGET_W  = 26;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd6,
    ALU_SLT = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BSRC_REG   = 2'd0,
    BSRC_FOUR  = 2'd1,
    BSRC_IMM   = 2'd2,
    BSRC_IMMSH = 2'd3
  } bsrc_e;

  typedef enum logic [1:0] {
    PCSRC_ALU  = 2'd0,
    PCSRC_RES  = 2'd1,
    PCSRC_JMP  = 2'd2,
    PCSRC_JMP2 = 2'd3
  } pcsrc_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  output logic [W-1:0] result
);
  logic less;

  assign less = $signed(opa) < $signed(opb);

  always_comb begin
    case (alu_op_e'(op))
      ALU_AND: result = opa & opb;
      ALU_OR:  result = opa | opb;
      ALU_ADD: result = opa + opb;
      ALU_SUB: result = opa - opb;
      ALU_SLT: result = {{(W-1){1'b0}}, less};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W       = 32,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [W-1:0]     rd_data_a,
  output logic [W-1:0]     rd_data_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data
);
  logic [W-1:0] bank [ENTRIES];

  // entry 0 is cleared by reset and never written afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ENTRIES); i++) bank[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = bank[rd_idx_a];
  assign rd_data_b = bank[rd_idx_b];
endmodule

// File: rtl/mc_memory.sv
module mc_memory #(
  parameter int unsigned W         = 32,
  parameter int unsigned WORDS     = 64,
  parameter int unsigned IMG_WORDS = 16,
  parameter logic [IMG_WORDS*W-1:0] IMAGE = '0,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  logic [W-1:0]     store [WORDS];
  logic [IDX_W-1:0] word_idx;
  logic [W-IDX_W-1:0] unused_addr_bits;

  assign word_idx         = addr[IDX_W+1:2];
  assign unused_addr_bits = {addr[W-1:IDX_W+2], addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(IMG_WORDS); i++) store[i] <= IMAGE[i*W +: W];
      for (int i = int'(IMG_WORDS); i < int'(WORDS); i++) store[i] <= '0;
    end else if (wr_en) begin
      store[word_idx] <= wr_data;
    end
  end

  assign rd_data = store[word_idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64,
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned IMG_WORDS = 16,
  parameter logic [IMG_WORDS*XLEN-1:0] BOOT_IMAGE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pc_we,
  input  logic         ir_we,
  input  logic         dr_we,
  input  logic         a_we,
  input  logic         b_we,
  input  logic         res_we,
  input  logic         addr_sel,
  input  logic         mem_we,
  input  logic         a_sel,
  input  logic [1:0]   b_sel,
  input  logic [1:0]   pc_sel,
  input  logic         wb_sel,
  input  logic         dst_sel,
  input  logic         rf_we,
  input  logic [2:0]   alu_op,
  output logic [5:0]   opcode,
  output logic [5:0]   funct,
  output logic         zero
);
  localparam int unsigned W     = XLEN;
  localparam int unsigned RIDX_W = $clog2(REG_COUNT);

  // holding registers
  logic [W-1:0] pc_q, ir_q, dr_q, a_q, b_q, res_q;

  // instruction fields
  logic [RIDX_W-1:0] src1_idx, src2_idx, dst_r_idx, wr_idx;
  logic [W-1:0]      imm_sx, imm_sx_sh, jump_tgt;

  // shared resources
  logic [W-1:0] mem_addr, mem_rdata;
  logic [W-1:0] rf_a, rf_b, wb_data;
  logic [W-1:0] alu_a, alu_b, alu_y;
  logic [W-1:0] pc_next, ab_diff;

  assign src1_idx  = ir_q[25:21];
  assign src2_idx  = ir_q[20:16];
  assign dst_r_idx = ir_q[15:11];
  assign imm_sx    = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sx_sh = {imm_sx[W-3:0], 2'b00};
  assign jump_tgt  = {pc_q[W-1:W-4], ir_q[TARGET_W-1:0], 2'b00};

  // memory address source
  assign mem_addr = addr_sel ? res_q : pc_q;

  mc_memory #(
    .W         (W),
    .WORDS     (MEM_WORDS),
    .IMG_WORDS (IMG_WORDS),
    .IMAGE     (BOOT_IMAGE)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (mem_addr),
    .wr_en   (mem_we),
    .wr_data (b_q),
    .rd_data (mem_rdata)
  );

  // register-file write path
  assign wr_idx  = dst_sel ? dst_r_idx : src2_idx;
  assign wb_data = wb_sel ? dr_q : res_q;

  mc_regfile #(
    .W       (W),
    .ENTRIES (REG_COUNT)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_a  (src1_idx),
    .rd_idx_b  (src2_idx),
    .rd_data_a (rf_a),
    .rd_data_b (rf_b),
    .wr_en     (rf_we),
    .wr_idx    (wr_idx),
    .wr_data   (wb_data)
  );

  // ALU operand sources
  assign alu_a = a_sel ? a_q : pc_q;

  always_comb begin
    case (bsrc_e'(b_sel))
      BSRC_REG:   alu_b = b_q;
      BSRC_FOUR:  alu_b = W'(4);
      BSRC_IMM:   alu_b = imm_sx;
      default:    alu_b = imm_sx_sh;
    endcase
  end

  mc_alu #(.W(W)) u_alu (
    .opa    (alu_a),
    .opb    (alu_b),
    .op     (alu_op),
    .result (alu_y)
  );

  // program counter source
  always_comb begin
    case (pcsrc_e'(pc_sel))
      PCSRC_ALU: pc_next = alu_y;
      PCSRC_RES: pc_next = res_q;
      default:   pc_next = jump_tgt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (pc_we)  pc_q  <= pc_next;
      if (ir_we)  ir_q  <= mem_rdata;
      if (dr_we)  dr_q  <= mem_rdata;
      if (a_we)   a_q   <= rf_a;
      if (b_we)   b_q   <= rf_b;
      if (res_we) res_q <= alu_y;
    end
  end

  assign ab_diff = a_q - b_q;
  assign zero    = ~|ab_diff;
  assign opcode  = ir_q[W-1:W-OPC_W];
  assign funct   = ir_q[FUNCT_W-1:0];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_we,
  input logic        ir_we,
  input logic        a_we,
  input logic        a_sel,
  input logic [1:0]  b_sel,
  input logic [1:0]  pc_sel,
  input logic [2:0]  alu_op,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] a_q,
  input logic [31:0] b_q,
  input logic [31:0] mem_rdata,
  input logic        zero
);
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q)); // R9

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q)); // R9

  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> ir_q == $past(mem_rdata)); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero == (a_q == b_q)); // R10

  AST_REG0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && ir_q[25:21] == 5'd0) |=> a_q == 32'd0); // R8

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_sel == 2'd0 && !a_sel && b_sel == 2'd1 && alu_op == 3'd2)
      |=> pc_q == $past(pc_q) + 32'd4); // R7

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_sel[1]) |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28]))); // R7
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc_we     (pc_we),
  .ir_we     (ir_we),
  .a_we      (a_we),
  .a_sel     (a_sel),
  .b_sel     (b_sel),
  .pc_sel    (pc_sel),
  .alu_op    (alu_op),
  .pc_q      (pc_q),
  .ir_q      (ir_q),
  .a_q       (a_q),
  .b_q       (b_q),
  .mem_rdata (mem_rdata),
  .zero      (zero)
);

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
  localparam int IMGW = 16;

  function automatic logic [IMGW*32-1:0] build_image();
    logic [IMGW*32-1:0] v;
    v = '0;
    v[0*32 +: 32]  = 32'h8C01_0028; // lw  r1, 40(r0)
    v[1*32 +: 32]  = 32'h8C02_002C; // lw  r2, 44(r0)
    v[2*32 +: 32]  = 32'h0022_1820; // add r3, r1, r2
    v[3*32 +: 32]  = 32'hAC03_0030; // sw  r3, 48(r0)
    v[4*32 +: 32]  = 32'h1021_0001; // beq r1, r1, +1
    v[5*32 +: 32]  = 32'h0041_2022; // sub (must be skipped)
    v[6*32 +: 32]  = 32'h0022_282A; // slt r5, r1, r2
    v[7*32 +: 32]  = 32'hAC05_0034; // sw  r5, 52(r0)
    v[8*32 +: 32]  = 32'h0800_000C; // j   word 12
    v[10*32 +: 32] = 32'h1000_0010;
    v[11*32 +: 32] = 32'h2000_0021;
    v[14*32 +: 32] = 32'hFC00_003F;
    v[15*32 +: 32] = 32'h0400_0002;
    return v;
  endfunction

  localparam logic [IMGW*32-1:0] IMAGE = build_image();

  // control word bit layout (bit 0 spare)
  localparam logic [19:0] F_PCW   = 20'h1 << 19;
  localparam logic [19:0] F_IRW   = 20'h1 << 18;
  localparam logic [19:0] F_DRW   = 20'h1 << 17;
  localparam logic [19:0] F_AW    = 20'h1 << 16;
  localparam logic [19:0] F_BW    = 20'h1 << 15;
  localparam logic [19:0] F_RESW  = 20'h1 << 14;
  localparam logic [19:0] F_ADRR  = 20'h1 << 13;
  localparam logic [19:0] F_MEMW  = 20'h1 << 12;
  localparam logic [19:0] F_ASELA = 20'h1 << 11;
  localparam logic [19:0] B_FOUR  = 20'h1 << 9;
  localparam logic [19:0] B_IMM   = 20'h2 << 9;
  localparam logic [19:0] B_IMMSH = 20'h3 << 9;
  localparam logic [19:0] P_RES   = 20'h1 << 7;
  localparam logic [19:0] P_JMP   = 20'h2 << 7;
  localparam logic [19:0] F_WBDR  = 20'h1 << 6;
  localparam logic [19:0] F_DSTRD = 20'h1 << 5;
  localparam logic [19:0] F_RFW   = 20'h1 << 4;
  localparam logic [19:0] O_ADD   = 20'h2 << 1;
  localparam logic [19:0] O_SUB   = 20'h6 << 1;
  localparam logic [19:0] O_SLT   = 20'h7 << 1;

  localparam logic [19:0] C_FETCH = F_PCW | F_IRW | B_FOUR | O_ADD;
  localparam logic [19:0] C_DEC   = F_AW | F_BW | F_RESW | B_IMMSH | O_ADD;
  localparam logic [19:0] C_ADDR  = F_RESW | F_ASELA | B_IMM | O_ADD;
  localparam logic [19:0] C_MRD   = F_ADRR | F_DRW;
  localparam logic [19:0] C_WBL   = F_RFW | F_WBDR;
  localparam logic [19:0] C_MWR   = F_ADRR | F_MEMW;
  localparam logic [19:0] C_ADD   = F_RESW | F_ASELA | O_ADD;
  localparam logic [19:0] C_SLT   = F_RESW | F_ASELA | O_SLT;
  localparam logic [19:0] C_WBR   = F_RFW | F_DSTRD;
  localparam logic [19:0] C_BRT   = F_PCW | P_RES | F_ASELA | O_SUB;
  localparam logic [19:0] C_JMP   = F_PCW | P_JMP;

  localparam int NVEC = 33;
  // {control, expected opcode, expected funct, expected zero}
  localparam logic [32:0] VEC [NVEC] = '{
    {C_FETCH, 6'h23, 6'h28, 1'b1},
    {C_DEC,   6'h23, 6'h28, 1'b1},
    {C_ADDR,  6'h23, 6'h28, 1'b1},
    {C_MRD,   6'h23, 6'h28, 1'b1},
    {C_WBL,   6'h23, 6'h28, 1'b1},
    {C_FETCH, 6'h23, 6'h2C, 1'b1},
    {C_DEC,   6'h23, 6'h2C, 1'b1},
    {C_ADDR,  6'h23, 6'h2C, 1'b1},
    {C_MRD,   6'h23, 6'h2C, 1'b1},
    {C_WBL,   6'h23, 6'h2C, 1'b1},
    {C_FETCH, 6'h00, 6'h20, 1'b1},
    {C_DEC,   6'h00, 6'h20, 1'b0},
    {C_ADD,   6'h00, 6'h20, 1'b0},
    {C_WBR,   6'h00, 6'h20, 1'b0},
    {C_FETCH, 6'h2B, 6'h30, 1'b0},
    {C_DEC,   6'h2B, 6'h30, 1'b0},
    {C_ADDR,  6'h2B, 6'h30, 1'b0},
    {C_MWR,   6'h2B, 6'h30, 1'b0},
    {C_FETCH, 6'h04, 6'h01, 1'b0},
    {C_DEC,   6'h04, 6'h01, 1'b1},
    {C_BRT,   6'h04, 6'h01, 1'b1},
    {C_FETCH, 6'h00, 6'h2A, 1'b1},
    {C_DEC,   6'h00, 6'h2A, 1'b0},
    {C_SLT,   6'h00, 6'h2A, 1'b0},
    {C_WBR,   6'h00, 6'h2A, 1'b0},
    {C_FETCH, 6'h2B, 6'h34, 1'b0},
    {C_DEC,   6'h2B, 6'h34, 1'b0},
    {C_ADDR,  6'h2B, 6'h34, 1'b0},
    {C_MWR,   6'h2B, 6'h34, 1'b0},
    {C_FETCH, 6'h02, 6'h0C, 1'b0},
    {C_JMP,   6'h02, 6'h0C, 1'b0},
    {C_FETCH, 6'h0C, 6'h31, 1'b0},
    {C_FETCH, 6'h00, 6'h01, 1'b0}
  };

  logic       clk, rst_n;
  logic       pc_we, ir_we, dr_we, a_we, b_we, res_we;
  logic       addr_sel, mem_we, a_sel, wb_sel, dst_sel, rf_we;
  logic [1:0] b_sel, pc_sel;
  logic [2:0] alu_op;
  logic [5:0] opcode, funct;
  logic       zero;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  mc_datapath #(
    .MEM_WORDS  (64),
    .REG_COUNT  (32),
    .IMG_WORDS  (IMGW),
    .BOOT_IMAGE (IMAGE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pc_we(pc_we), .ir_we(ir_we), .dr_we(dr_we), .a_we(a_we), .b_we(b_we),
    .res_we(res_we), .addr_sel(addr_sel), .mem_we(mem_we), .a_sel(a_sel),
    .b_sel(b_sel), .pc_sel(pc_sel), .wb_sel(wb_sel), .dst_sel(dst_sel),
    .rf_we(rf_we), .alu_op(alu_op),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input logic [19:0] c);
    {pc_we, ir_we, dr_we, a_we, b_we, res_we, addr_sel, mem_we, a_sel,
     b_sel, pc_sel, wb_sel, dst_sel, rf_we, alu_op} = c[19:1];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [19:0] c);
    drive(c);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(20'h0);
    repeat (3) @(negedge clk);
    // R1: outputs while held in reset
    check("R1", {20'h0, opcode, funct}, {20'h0, 6'h00, 6'h00});
    check("R1", {31'h0, zero}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {19'h0, opcode, funct, zero}, {19'h0, 6'h00, 6'h00, 1'b1});

    // program walk: fetch, branch skip, jump and store are judged through the fetched words
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][32:13]);
      check("R3 R5 R6 R7 R11", {20'h0, opcode, funct}, {20'h0, VEC[i][12:1]});
      check("R10", {31'h0, zero}, {31'h0, VEC[i][0]});
    end

    // R9: idle cycles leave every output unchanged
    for (int k = 0; k < 3; k++) begin
      step(20'h0);
      check("R9", {19'h0, opcode, funct, zero}, {19'h0, 6'h00, 6'h01, 1'b0});
    end
    // R9: program counter held at 56, so word 14 is fetched now
    step(C_FETCH);
    check("R9", {20'h0, opcode, funct}, {20'h0, 6'h3F, 6'h3F});
    // R2: address from held result (52) selects word 13, not the program counter
    step(F_ADRR | F_IRW);
    check("R2", {20'h0, opcode, funct}, {20'h0, 6'h00, 6'h01});

    // R1: reset in mid-run returns to the reset outputs
    rst_n = 1'b0;
    drive(20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {19'h0, opcode, funct, zero}, {19'h0, 6'h00, 6'h00, 1'b1});
    // R1: boot image reloaded, word 0 is fetched from program counter 0
    step(C_FETCH);
    check("R1", {20'h0, opcode, funct}, {20'h0, 6'h23, 6'h28});

    // R8: write 8 (PC+4) to entry 0 through field [15:11] = 0, then read it back
    step(F_RESW | B_FOUR | O_ADD);
    step(F_RFW | F_DSTRD);
    step(F_AW | F_BW);
    check("R8", {31'h0, zero}, 32'h1);

    // R4: write entry 1 and capture operands on the same edge: old value seen
    step(F_RFW | F_AW | F_BW);
    check("R4", {31'h0, zero}, 32'h1);
    // R4: next capture sees the written value 8 in operand B
    step(F_AW | F_BW);
    check("R4", {31'h0, zero}, 32'h0);

    finished = 1;
    summary();
    $finish;
  end
endmodule